// File: doc/BRIEF.md
# Fast Privilege-Transition Sequencer

This block computes the architectural state a processor core must load when it executes a fast kernel-entry or kernel-exit instruction that relies on a fixed selector layout. It holds three configuration registers: a base code selector, a kernel stack pointer and a kernel entry address. Software reaches these registers through a small indexed write port and a combinational read port.

When the core raises an entry or exit request, the block derives the new code and stack selectors from the single base selector at fixed offsets. It picks the instruction pointer and stack pointer from its own registers on entry, or from two general-register inputs on exit. It also produces the new privilege level and the adjusted flags word. The result appears on registered outputs, with a one-cycle valid pulse, on the clock after the request. A request made while the base selector is null produces a one-cycle fault pulse instead, and the state outputs are left unchanged. Descriptor lookup, memory access and decode are handled elsewhere.

Top module: `priv_xfer_unit`

## Requirements
- R1: While reset is held, and right after it is released, `upd_valid`, `gp_fault` and every state output are zero, and each of the three registers reads back zero.
- R2: Register index 0x174 holds the base selector. It stores only write-data bits 15:0 and reads back zero-extended. Index 0x175 holds the kernel stack pointer and index 0x176 holds the kernel entry address; both are full-width. A read of any other index returns zero, and a write to any other index changes none of the three registers.
- R3: A register write takes effect at the clock edge on which it is sampled. An entry request sampled on that same edge uses the register's previous value.
- R4: On entry, `new_cs` is the base selector with bits 1:0 forced to 0, and `new_ss` is (base + 8) with bits 1:0 forced to 0. `new_ip` is the entry-address register, `new_sp` is the stack-pointer register, and `new_cpl` is 0.
- R5: On entry, `new_flags` equals `flags_in` with bit 9 (interrupt enable), bit 16 (resume) and bit 17 (virtual-8086) cleared and all other bits copied. On exit, `new_flags` equals `flags_in` unchanged.
- R6: On exit with `op64` low, `new_cs` is (base + 16) and `new_ss` is (base + 24), each with bits 1:0 forced to 3. `new_ip` is `gpr_rdx`, `new_sp` is `gpr_rcx`, and `new_cpl` is 3.
- R7: On exit with `op64` high, `new_cs` is (base + 32) and `new_ss` is (base + 40), each with bits 1:0 forced to 3. The sums wrap modulo 2^16.
- R8: With `mode64` low, `new_ip` and `new_sp` carry only the low 32 bits of their source, and bits 63:32 are zero. With `mode64` high, they carry all 64 bits.
- R9: If base-selector bits 15:2 are all zero when a request is sampled, `gp_fault` pulses for one cycle, `upd_valid` stays low, and all state outputs keep their values.
- R10: Results appear on the clock edge after the request is sampled. `upd_valid` or `gp_fault` is high for exactly that one cycle per request. With no request, both stay low and the state outputs hold.
- R11: If entry and exit are requested in the same cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register index for reads and writes |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for `cfg_addr` (combinational) |
| mode64 | input | 1 | Core is in 64-bit mode |
| req_enter | input | 1 | Kernel-entry request |
| req_exit | input | 1 | Kernel-exit request |
| op64 | input | 1 | Exit uses 64-bit operand size |
| gpr_rdx | input | 64 | Return address source for exit |
| gpr_rcx | input | 64 | User stack pointer source for exit |
| flags_in | input | 32 | Current flags word |
| upd_valid | output | 1 | One-cycle pulse: state outputs updated |
| gp_fault | output | 1 | One-cycle pulse: request refused, null base selector |
| new_cs | output | 16 | New code selector |
| new_ss | output | 16 | New stack selector |
| new_ip | output | 64 | New instruction pointer |
| new_sp | output | 64 | New stack pointer |
| new_cpl | output | 2 | New privilege level |
| new_flags | output | 32 | New flags word |

## Verification
The assertions assume that every input is driven to a known value after reset. They also assume that `mode64`, `op64`, `flags_in` and the two general-register inputs matter only in the cycle a request is sampled, so a check on an output looks back exactly one cycle to the request. The bench holds every input at zero during reset and changes inputs only on the falling clock edge. It raises each request for exactly one sampled edge and returns all request inputs to zero before it samples the result.

// File: rtl/priv_xfer_pkg.sv
// Package: priv_xfer_pkg
// Shared selector type, request kinds, selector offsets and flag bit
// positions for the fast privilege-transition sequencer.
// Assumes 16-bit selectors whose two low bits carry the requested privilege.
package priv_xfer_pkg;

    localparam int SEL_W = 16;
    typedef logic [SEL_W-1:0] sel_t;

    // Kind of transition decided for the current request.
    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_ENTER = 2'd1,
        XF_EXIT  = 2'd2,
        XF_FAULT = 2'd3
    } xf_kind_e;

    // Selector offsets from the base selector.
    localparam sel_t OFS_ENTER_SS  = sel_t'(8);
    localparam sel_t OFS_EXIT_CS   = sel_t'(16);
    localparam sel_t OFS_EXIT_SS   = sel_t'(24);
    localparam sel_t OFS_EXIT64_CS = sel_t'(32);
    localparam sel_t OFS_EXIT64_SS = sel_t'(40);

    // Privilege levels.
    localparam logic [1:0] RING_KERNEL = 2'd0;
    localparam logic [1:0] RING_USER   = 2'd3;

    // Flag bit positions cleared on entry.
    localparam int FLAG_IF_BIT = 9;
    localparam int FLAG_RF_BIT = 16;
    localparam int FLAG_VM_BIT = 17;

    // Add an offset to a selector and replace its privilege field.
    function automatic sel_t make_sel(input sel_t base, input sel_t ofs,
                                      input logic [1:0] rpl);
        sel_t sum;
        sum = base + ofs;
        return {sum[SEL_W-1:2], rpl};
    endfunction

endpackage

// File: rtl/priv_xfer_msr.sv
// Module: priv_xfer_msr
// Holds the base selector and the two full-width pointer registers, and
// serves the indexed write port and the combinational read port.
// Assumes the pointer registers sit at consecutive indices just above the
// base-selector index. Unmapped indices read zero and ignore writes.
module priv_xfer_msr
    import priv_xfer_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              IDX_W    = 12,
    parameter logic [IDX_W-1:0] IDX_BASE = 12'h174
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [XLEN-1:0]  cfg_wdata,
    output logic [XLEN-1:0]  cfg_rdata,
    output sel_t             base_sel,
    output logic [XLEN-1:0]  kstack,
    output logic [XLEN-1:0]  kentry
);

    localparam int NWIDE = 2;   // stack pointer, then entry address

    sel_t            base_q;
    logic [XLEN-1:0] wide_val [NWIDE];

    // Base selector register: keeps only the selector width of write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (cfg_wr && cfg_addr == IDX_BASE) begin
            base_q <= cfg_wdata[SEL_W-1:0];
        end
    end

    // Full-width pointer registers at the indices following the base.
    for (genvar g = 0; g < NWIDE; g++) begin : g_wide
        localparam logic [IDX_W-1:0] MY_IDX = IDX_BASE + IDX_W'(g + 1);
        logic [XLEN-1:0] q;

        // Load this pointer register when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (cfg_wr && cfg_addr == MY_IDX) begin
                q <= cfg_wdata;
            end
        end

        assign wide_val[g] = q;
    end

    // Read mux: zero-extended base, pointers, zero for anything else.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == IDX_BASE) begin
            cfg_rdata = {{(XLEN-SEL_W){1'b0}}, base_q};
        end else if (cfg_addr == IDX_BASE + IDX_W'(1)) begin
            cfg_rdata = wide_val[0];
        end else if (cfg_addr == IDX_BASE + IDX_W'(2)) begin
            cfg_rdata = wide_val[1];
        end
    end

    assign base_sel = base_q;
    assign kstack   = wide_val[0];
    assign kentry   = wide_val[1];

endmodule

// File: rtl/priv_xfer_calc.sv
// Module: priv_xfer_calc
// Combinational next-state calculation for an entry or exit request:
// selectors, pointers, privilege and flags, plus the kind of transition.
// Assumes XLEN is above 32 so that the 32-bit narrowing mask is meaningful.
// Entry wins when both requests are present.
module priv_xfer_calc
    import priv_xfer_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int FLAG_W = 32
) (
    input  sel_t              base_sel,
    input  logic [XLEN-1:0]   kstack,
    input  logic [XLEN-1:0]   kentry,
    input  logic              mode64,
    input  logic              req_enter,
    input  logic              req_exit,
    input  logic              op64,
    input  logic [XLEN-1:0]   gpr_rdx,
    input  logic [XLEN-1:0]   gpr_rcx,
    input  logic [FLAG_W-1:0] flags_in,
    output xf_kind_e          kind,
    output sel_t              nx_cs,
    output sel_t              nx_ss,
    output logic [XLEN-1:0]   nx_ip,
    output logic [XLEN-1:0]   nx_sp,
    output logic [1:0]        nx_cpl,
    output logic [FLAG_W-1:0] nx_flags
);

    localparam logic [XLEN-1:0] LO32_MASK =
        {{(XLEN-32){1'b0}}, {32{1'b1}}};
    localparam logic [FLAG_W-1:0] ENTRY_CLR =
        (FLAG_W'(1) << FLAG_IF_BIT) |
        (FLAG_W'(1) << FLAG_RF_BIT) |
        (FLAG_W'(1) << FLAG_VM_BIT);

    logic            base_null;
    logic [XLEN-1:0] ip_raw;
    logic [XLEN-1:0] sp_raw;

    // A selector whose index and table bits are all zero is null.
    assign base_null = (base_sel[SEL_W-1:2] == '0);

    // Decide the transition kind, giving entry priority over exit.
    always_comb begin
        if (req_enter) begin
            kind = base_null ? XF_FAULT : XF_ENTER;
        end else if (req_exit) begin
            kind = base_null ? XF_FAULT : XF_EXIT;
        end else begin
            kind = XF_NONE;
        end
    end

    // Derive selectors and privilege from the base at fixed offsets.
    always_comb begin
        if (req_enter) begin
            nx_cs  = make_sel(base_sel, '0, RING_KERNEL);
            nx_ss  = make_sel(base_sel, OFS_ENTER_SS, RING_KERNEL);
            nx_cpl = RING_KERNEL;
        end else if (op64) begin
            nx_cs  = make_sel(base_sel, OFS_EXIT64_CS, RING_USER);
            nx_ss  = make_sel(base_sel, OFS_EXIT64_SS, RING_USER);
            nx_cpl = RING_USER;
        end else begin
            nx_cs  = make_sel(base_sel, OFS_EXIT_CS, RING_USER);
            nx_ss  = make_sel(base_sel, OFS_EXIT_SS, RING_USER);
            nx_cpl = RING_USER;
        end
    end

    // Pick pointer sources: own registers on entry, general registers on exit.
    always_comb begin
        ip_raw = req_enter ? kentry : gpr_rdx;
        sp_raw = req_enter ? kstack : gpr_rcx;
    end

    // Narrow pointers to 32 bits outside 64-bit mode.
    always_comb begin
        nx_ip = mode64 ? ip_raw : (ip_raw & LO32_MASK);
        nx_sp = mode64 ? sp_raw : (sp_raw & LO32_MASK);
    end

    // Clear interrupt, resume and virtual-8086 flags on entry only.
    always_comb begin
        nx_flags = req_enter ? (flags_in & ~ENTRY_CLR) : flags_in;
    end

endmodule

// File: rtl/priv_xfer_unit.sv
// Module: priv_xfer_unit (top)
// Fast privilege-transition sequencer. It holds the configuration registers,
// computes the entry or exit state, and registers it with a one-cycle valid
// or fault pulse. Assumes a request is presented for one sampled edge and its
// side inputs are valid in that cycle. Reset is synchronous and active low.
module priv_xfer_unit
    import priv_xfer_pkg::*;
#(
    parameter int               XLEN     = 64,
    parameter int               FLAG_W   = 32,
    parameter int               IDX_W    = 12,
    parameter logic [IDX_W-1:0] IDX_BASE = 12'h174
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [XLEN-1:0]   cfg_wdata,
    output logic [XLEN-1:0]   cfg_rdata,
    input  logic              mode64,
    input  logic              req_enter,
    input  logic              req_exit,
    input  logic              op64,
    input  logic [XLEN-1:0]   gpr_rdx,
    input  logic [XLEN-1:0]   gpr_rcx,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              upd_valid,
    output logic              gp_fault,
    output logic [15:0]       new_cs,
    output logic [15:0]       new_ss,
    output logic [XLEN-1:0]   new_ip,
    output logic [XLEN-1:0]   new_sp,
    output logic [1:0]        new_cpl,
    output logic [FLAG_W-1:0] new_flags
);

    sel_t              base_sel;
    logic [XLEN-1:0]   kstack;
    logic [XLEN-1:0]   kentry;
    xf_kind_e          kind;
    sel_t              nx_cs;
    sel_t              nx_ss;
    logic [XLEN-1:0]   nx_ip;
    logic [XLEN-1:0]   nx_sp;
    logic [1:0]        nx_cpl;
    logic [FLAG_W-1:0] nx_flags;
    logic              do_update;

    priv_xfer_msr #(
        .XLEN    (XLEN),
        .IDX_W   (IDX_W),
        .IDX_BASE(IDX_BASE)
    ) u_msr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .base_sel (base_sel),
        .kstack   (kstack),
        .kentry   (kentry)
    );

    priv_xfer_calc #(
        .XLEN  (XLEN),
        .FLAG_W(FLAG_W)
    ) u_calc (
        .base_sel (base_sel),
        .kstack   (kstack),
        .kentry   (kentry),
        .mode64   (mode64),
        .req_enter(req_enter),
        .req_exit (req_exit),
        .op64     (op64),
        .gpr_rdx  (gpr_rdx),
        .gpr_rcx  (gpr_rcx),
        .flags_in (flags_in),
        .kind     (kind),
        .nx_cs    (nx_cs),
        .nx_ss    (nx_ss),
        .nx_ip    (nx_ip),
        .nx_sp    (nx_sp),
        .nx_cpl   (nx_cpl),
        .nx_flags (nx_flags)
    );

    assign do_update = (kind == XF_ENTER) || (kind == XF_EXIT);

    // Raise the one-cycle valid or fault pulse for the sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            gp_fault  <= 1'b0;
        end else begin
            upd_valid <= do_update;
            gp_fault  <= (kind == XF_FAULT);
        end
    end

    // Load the state outputs on an accepted request; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_cs    <= '0;
            new_ss    <= '0;
            new_ip    <= '0;
            new_sp    <= '0;
            new_cpl   <= '0;
            new_flags <= '0;
        end else if (do_update) begin
            new_cs    <= nx_cs;
            new_ss    <= nx_ss;
            new_ip    <= nx_ip;
            new_sp    <= nx_sp;
            new_cpl   <= nx_cpl;
            new_flags <= nx_flags;
        end
    end

    localparam logic [FLAG_W-1:0] CLR_CHK =
        (FLAG_W'(1) << FLAG_IF_BIT) |
        (FLAG_W'(1) << FLAG_RF_BIT) |
        (FLAG_W'(1) << FLAG_VM_BIT);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && gp_fault)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_enter || req_exit) |=> (!upd_valid && !gp_fault)); // R10

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> ($stable(new_cs) && $stable(new_ss) && $stable(new_ip)
                        && $stable(new_sp) && $stable(new_cpl))); // R10

    AST_CPL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (new_cpl == RING_KERNEL || new_cpl == RING_USER)); // R4

    AST_ENTRY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && new_cpl == RING_KERNEL) |->
        (new_cs[1:0] == 2'd0 && new_ss == sel_t'(new_cs + sel_t'(8)))); // R4

    AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && new_cpl == RING_KERNEL) |->
        ((new_flags & CLR_CHK) == '0)); // R5

    AST_EXIT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && new_cpl == RING_USER) |->
        (new_cs[1:0] == 2'd3 && new_ss == sel_t'(new_cs + sel_t'(8)))); // R6

    AST_NARROW_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !$past(mode64)) |->
        (new_ip[XLEN-1:32] == '0 && new_sp[XLEN-1:32] == '0)); // R8

    AST_FAULT_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> ($past(base_sel[SEL_W-1:2]) == '0)); // R9

    AST_BOTH_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(req_enter && req_exit)) |->
        (new_cpl == RING_KERNEL)); // R11

endmodule

// File: tb/priv_xfer_unit_bench.sv
// Directed bench for priv_xfer_unit: one task per scenario, each checking
// its own results against values computed from the requirements.
module priv_xfer_unit_bench;

    localparam logic [11:0] I_BASE  = 12'h174;
    localparam logic [11:0] I_STACK = 12'h175;
    localparam logic [11:0] I_ENTRY = 12'h176;
    localparam logic [31:0] ENTRY_CLR = 32'h0003_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        mode64 = 1'b0;
    logic        req_enter = 1'b0;
    logic        req_exit = 1'b0;
    logic        op64 = 1'b0;
    logic [63:0] gpr_rdx = '0;
    logic [63:0] gpr_rcx = '0;
    logic [31:0] flags_in = '0;
    logic        upd_valid;
    logic        gp_fault;
    logic [15:0] new_cs;
    logic [15:0] new_ss;
    logic [63:0] new_ip;
    logic [63:0] new_sp;
    logic [1:0]  new_cpl;
    logic [31:0] new_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Bench-side shadow of the three registers.
    logic [15:0] m_base = '0;
    logic [63:0] m_stack = '0;
    logic [63:0] m_entry = '0;

    priv_xfer_unit u_priv_xfer_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode64(mode64),
        .req_enter(req_enter), .req_exit(req_exit), .op64(op64),
        .gpr_rdx(gpr_rdx), .gpr_rcx(gpr_rcx), .flags_in(flags_in),
        .upd_valid(upd_valid), .gp_fault(gp_fault), .new_cs(new_cs),
        .new_ss(new_ss), .new_ip(new_ip), .new_sp(new_sp),
        .new_cpl(new_cpl), .new_flags(new_flags)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] sel_of(input logic [15:0] b,
                                           input int ofs, input logic [1:0] rpl);
        logic [15:0] s;
        s = b + 16'(ofs);
        return {s[15:2], rpl};
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a,
                            input logic [63:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #0.5;
        check(req, cfg_rdata, exp);
    endtask

    // Drive one request for one sampled edge; return at the next falling edge.
    task automatic issue(input bit en, input bit ex, input bit o64,
                         input bit m64, input logic [63:0] rdx,
                         input logic [63:0] rcx, input logic [31:0] fl);
        @(negedge clk);
        req_enter = en; req_exit = ex; op64 = o64; mode64 = m64;
        gpr_rdx = rdx; gpr_rcx = rcx; flags_in = fl;
        @(posedge clk);
        @(negedge clk);
        req_enter = 1'b0; req_exit = 1'b0; op64 = 1'b0;
        gpr_rdx = '0; gpr_rcx = '0; flags_in = '0;
    endtask

    task automatic t_reset();
        check("R1 valid", 64'(upd_valid), 0);
        check("R1 fault", 64'(gp_fault), 0);
        check("R1 cs", 64'(new_cs), 0);
        check("R1 ip", new_ip, 0);
        check("R1 sp", new_sp, 0);
        rd_check("R1 base", I_BASE, 0);
        rd_check("R1 stack", I_STACK, 0);
        rd_check("R1 entry", I_ENTRY, 0);
    endtask

    task automatic t_null();
        issue(1, 0, 0, 1, 64'h0, 64'h0, 32'hFFFF_FFFF);
        check("R9 fault", 64'(gp_fault), 1);
        check("R9 no valid", 64'(upd_valid), 0);
        check("R9 ip held", new_ip, 0);
        @(negedge clk);
        check("R10 fault pulse", 64'(gp_fault), 0);
        wr(I_BASE, 64'h3);   // null selector with nonzero privilege field
        issue(0, 1, 0, 1, 64'h55, 64'h66, 0);
        check("R9 rpl-only base fault", 64'(gp_fault), 1);
        check("R9 cs held", 64'(new_cs), 0);
    endtask

    task automatic t_regs();
        wr(I_BASE, 64'hABCD_0000_0000_0123); m_base = 16'h0123;
        wr(I_STACK, 64'hFFFF_8000_1234_5670); m_stack = 64'hFFFF_8000_1234_5670;
        wr(I_ENTRY, 64'hFFFF_8000_DEAD_BEE0); m_entry = 64'hFFFF_8000_DEAD_BEE0;
        rd_check("R2 base zero-extended", I_BASE, 64'h0123);
        rd_check("R2 stack", I_STACK, m_stack);
        rd_check("R2 entry", I_ENTRY, m_entry);
        wr(12'h177, 64'h1111_2222_3333_4444);
        rd_check("R2 unmapped read", 12'h177, 0);
        wr(12'h173, 64'h9999);
        rd_check("R2 unmapped write ignored", I_BASE, 64'(m_base));
        rd_check("R2 unmapped write ignored stack", I_STACK, m_stack);
    endtask

    task automatic t_enter();
        issue(1, 0, 0, 1, 64'h77, 64'h88, 32'hFFFF_FFFF);
        check("R10 valid", 64'(upd_valid), 1);
        check("R4 cs", 64'(new_cs), 64'(sel_of(m_base, 0, 0)));
        check("R4 ss", 64'(new_ss), 64'(sel_of(m_base, 8, 0)));
        check("R4 ip", new_ip, m_entry);
        check("R4 sp", new_sp, m_stack);
        check("R4 cpl", 64'(new_cpl), 0);
        check("R5 entry flags", 64'(new_flags), 64'(32'hFFFF_FFFF & ~ENTRY_CLR));
        @(negedge clk);
        check("R10 valid pulse", 64'(upd_valid), 0);
    endtask

    task automatic t_exit32();
        issue(0, 1, 0, 1, 64'h0000_7FFF_0000_1000, 64'h0000_7FFF_FFFF_E000,
              32'h0003_0202);
        check("R6 cs", 64'(new_cs), 64'(sel_of(m_base, 16, 3)));
        check("R6 ss", 64'(new_ss), 64'(sel_of(m_base, 24, 3)));
        check("R6 ip", new_ip, 64'h0000_7FFF_0000_1000);
        check("R6 sp", new_sp, 64'h0000_7FFF_FFFF_E000);
        check("R6 cpl", 64'(new_cpl), 3);
        check("R5 exit flags", 64'(new_flags), 64'h0003_0202);
    endtask

    task automatic t_exit64();
        issue(0, 1, 1, 1, 64'hA, 64'hB, 0);
        check("R7 cs", 64'(new_cs), 64'(sel_of(m_base, 32, 3)));
        check("R7 ss", 64'(new_ss), 64'(sel_of(m_base, 40, 3)));
        wr(I_BASE, 64'hFFF8); m_base = 16'hFFF8;
        issue(0, 1, 1, 1, 64'hA, 64'hB, 0);
        check("R7 cs wrap", 64'(new_cs), 64'h001B);
        check("R7 ss wrap", 64'(new_ss), 64'h0023);
        wr(I_BASE, 64'h0123); m_base = 16'h0123;
    endtask

    task automatic t_mode32();
        issue(1, 0, 0, 0, 0, 0, 0);
        check("R8 entry ip narrowed", new_ip, {32'h0, m_entry[31:0]});
        check("R8 entry sp narrowed", new_sp, {32'h0, m_stack[31:0]});
        issue(0, 1, 0, 0, 64'hCAFE_0000_0040_1000, 64'hBEEF_0000_00BF_F000, 0);
        check("R8 exit ip narrowed", new_ip, 64'h0040_1000);
        check("R8 exit sp narrowed", new_sp, 64'h00BF_F000);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = I_ENTRY; cfg_wdata = 64'h0000_1234_0000_5000;
        req_enter = 1'b1; mode64 = 1'b1; flags_in = 0;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; req_enter = 1'b0;
        check("R3 same-cycle uses old", new_ip, m_entry);
        m_entry = 64'h0000_1234_0000_5000;
        issue(1, 0, 0, 1, 0, 0, 0);
        check("R3 new value next", new_ip, m_entry);
    endtask

    task automatic t_both();
        issue(1, 1, 1, 1, 64'h42, 64'h43, 0);
        check("R11 cpl", 64'(new_cpl), 0);
        check("R11 cs", 64'(new_cs), 64'(sel_of(m_base, 0, 0)));
        check("R11 ip", new_ip, m_entry);
    endtask

    task automatic t_hold();
        issue(0, 1, 0, 1, 64'h900, 64'h901, 0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R10 idle no valid", 64'(upd_valid), 0);
        check("R10 idle no fault", 64'(gp_fault), 0);
        check("R10 ip held", new_ip, 64'h900);
        check("R10 cs held", 64'(new_cs), 64'(sel_of(m_base, 16, 3)));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();       // checked while reset held
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();       // and right after release
        t_null();
        t_regs();
        t_enter();
        t_exit32();
        t_exit64();
        t_mode32();
        t_same_cycle();
        t_both();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule